// File: doc/BRIEF.md
# DDR2 Burst Latency and Column Sequencer

This block sits behind the command path of a DDR2 memory controller. Each accepted read or write command carries a starting column, a bank and an auto-precharge flag. The block holds the command until its data window opens. For a read, that window opens after the programmed additive latency plus CAS latency. For a write, it opens one clock earlier. The block then drives the data beats of the burst, two per clock: one for the rising half and one for the falling half. For each beat it gives the column address, in either sequential or interleaved order within the burst's nibble or octet.

Commands that arrive while an earlier burst is still pending wait in a small in-order queue. Each one starts at its own due clock, or right after the previous burst's final clock if that comes later, so back-to-back bursts leave no gap. The burst mode and latencies come from an 8-bit mode register. The register rejects combinations the memory does not support. Each command takes a copy of the mode at the moment it is accepted.

Top module: `ddr2_burst_seq`

## Requirements
- R1: The mode register resets to 0x03 and `cfg_rdata` always shows its contents. The field layout is: bits [2:0] CAS latency, bits [5:3] additive latency, bit 6 burst of 8 (0 means burst of 4), bit 7 interleaved order (0 means sequential). A write with `cfg_wr` high replaces the whole register.
- R2: A mode write whose CAS latency is outside 3..5, or whose additive latency is above 5, is ignored as a whole. The register keeps its earlier value, and later commands keep the earlier latencies.
- R3: For a read accepted at clock edge E (`cmd_valid` and `cmd_ready` both high), the first beat pair is on the outputs in the clock that follows edge E+AL+CL, unless R8 delays it.
- R4: For a write, the same distance is AL+CL−1 edges.
- R5: A burst drives two beats per clock, so a burst of 4 takes 2 clocks and a burst of 8 takes 4 clocks. `beat_idx` gives the index of the rising-half beat (0, 2, 4, 6), and the falling-half beat is that index plus 1. `beat_last` is high only in the burst's final clock. `beat_write` and `beat_bank` repeat the command's values.
- R6: In sequential order, the two low column bits of beat i are (start + i) mod 4. In a burst of 8, column bit 2 is the start value for beats 0–3 and inverted for beats 4–7. All other column bits equal the starting column.
- R7: In interleaved order, the column of beat i is the starting column XOR i. Only the low 2 bits change for a burst of 4, and only the low 3 bits for a burst of 8.
- R8: Bursts come out in acceptance order. Each one starts at the later of its own due clock and the clock right after the previous burst's final clock, with no idle clock between them when the command is already due.
- R9: Burst length, order and latency are fixed from the mode register at the edge where the command is accepted. A mode write made after that edge does not change the burst.
- R10: `pre_req` is high in the final clock of a burst whose command had `cmd_autopre` set, with the bank on `beat_bank`. It is low in every other clock.
- R11: `cmd_ready` is low while the queue holds its full depth (4 by default) of commands that have not yet started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Mode register write strobe |
| cfg_wdata | input | 8 | Mode value to write |
| cfg_rdata | output | 8 | Current mode register contents |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Queue can take a command |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_col | input | COL_W (11) | Starting column |
| cmd_bank | input | BANK_W (2) | Target bank |
| cmd_autopre | input | 1 | Close the bank after the burst |
| beat_valid | output | 1 | A beat pair is driven this clock |
| beat_write | output | 1 | The current burst is a write |
| beat_bank | output | BANK_W (2) | Bank of the current burst |
| beat_idx | output | 3 | Index of the rising-half beat |
| beat_col_rise | output | COL_W (11) | Column of the rising-half beat |
| beat_col_fall | output | COL_W (11) | Column of the falling-half beat |
| beat_last | output | 1 | Final clock of the burst |
| pre_req | output | 1 | Auto-precharge request for `beat_bank` |

## Verification
Some rules are checked on every cycle by properties. The mode register must always hold a legal combination and may change only when written. The beat counter must advance by exactly one pair per clock until the burst ends. The queue must never be pushed when full, and the sequencer may take a command only once its wait has run out. A precharge request must coincide with a final beat. Other behaviour can only be shown by the bench's scenarios: the absolute latency counted from acceptance, the exact column sequence for each order and length, gapless chaining of queued bursts, the copy of the mode taken at acceptance, and rejection of illegal mode writes. There the scoreboard predicts every beat pair and the clock it must appear in.

// File: rtl/ddr2_seq_pkg.sv
package ddr2_seq_pkg;

    localparam int COL_W   = 11;
    localparam int BANK_W  = 2;
    localparam int LAT_W   = 3;
    localparam int CL_MIN  = 3;
    localparam int CL_MAX  = 5;
    localparam int AL_MAX  = 5;
    localparam int WAIT_W  = $clog2(AL_MAX + CL_MAX + 1);
    localparam int BEATS_PER_CLK = 2;

    // Mode register layout: MSB first
    typedef struct packed {
        logic             ilv;   // bit 7: interleaved order
        logic             bl8;   // bit 6: burst of 8
        logic [LAT_W-1:0] al;    // bits 5:3
        logic [LAT_W-1:0] cl;    // bits 2:0
    } mode_t;

    localparam mode_t MODE_RESET = '{ilv: 1'b0, bl8: 1'b0, al: 3'd0, cl: 3'd3};

    typedef struct packed {
        logic              wr;
        logic              autopre;
        logic              bl8;
        logic              ilv;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
    } burst_cmd_t;

    function automatic logic mode_legal(mode_t m);
        return (m.cl >= LAT_W'(CL_MIN)) && (m.cl <= LAT_W'(CL_MAX)) &&
               (m.al <= LAT_W'(AL_MAX));
    endfunction

    // Clocks a queued command waits after its push edge before the sequencer may load it
    function automatic logic [WAIT_W-1:0] due_wait(mode_t m, logic is_wr);
        return WAIT_W'(m.al) + WAIT_W'(m.cl) - WAIT_W'(1) - WAIT_W'(is_wr);
    endfunction

    // Column of beat idx inside a burst
    function automatic logic [COL_W-1:0] beat_column(logic [COL_W-1:0] start,
                                                     logic [2:0] idx,
                                                     logic bl8, logic ilv);
        logic [COL_W-1:0] c;
        c = start;
        if (ilv) begin
            c[1:0] = start[1:0] ^ idx[1:0];
            c[2]   = start[2] ^ (idx[2] & bl8);
        end else begin
            c[1:0] = start[1:0] + idx[1:0];
            c[2]   = start[2] ^ (idx[2] & bl8);
        end
        return c;
    endfunction

endpackage

// File: rtl/ddr2_mode_reg.sv
module ddr2_mode_reg
    import ddr2_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  mode_t wr_mode,
    output mode_t mode
);

    mode_t mode_q;
    logic  accept;

    assign accept = wr_en && mode_legal(wr_mode);
    assign mode   = mode_q;

    always_ff @(posedge clk) begin
        if (rst)         mode_q <= MODE_RESET;
        else if (accept) mode_q <= wr_mode;
    end

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (mode_q.cl >= 3'd3) && (mode_q.cl <= 3'd5) && (mode_q.al <= 3'd5)); // R2

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(mode_q)); // R1

endmodule

// File: rtl/ddr2_cmd_queue.sv
module ddr2_cmd_queue
    import ddr2_seq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  burst_cmd_t        push_cmd,
    input  logic [WAIT_W-1:0] push_wait,
    input  logic              pop,
    output burst_cmd_t        head_cmd,
    output logic              head_due,
    output logic              not_full
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    burst_cmd_t        slot_q [DEPTH];
    logic [WAIT_W-1:0] wait_q [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;
    logic              head_valid;

    function automatic logic [PTR_W-1:0] next_ptr(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign head_valid = (count != '0);
    assign head_cmd   = slot_q[rd_ptr];
    assign head_due   = head_valid && (wait_q[rd_ptr] == '0);
    assign not_full   = (count < CNT_W'(DEPTH));

    // Every slot counts down toward its due clock, whatever its position
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst) begin
                slot_q[i] <= '0;
                wait_q[i] <= '0;
            end else if (push && (wr_ptr == PTR_W'(i))) begin
                slot_q[i] <= push_cmd;
                wait_q[i] <= push_wait;
            end else if (wait_q[i] != '0) begin
                wait_q[i] <= wait_q[i] - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= next_ptr(wr_ptr);
            if (pop)  rd_ptr <= next_ptr(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        push |-> (count < CNT_W'(DEPTH))); // R11

    AST_POP_ONLY_DUE: assert property (@(posedge clk) disable iff (rst)
        pop |-> (head_valid && (wait_q[rd_ptr] == '0))); // R8

endmodule

// File: rtl/ddr2_beat_engine.sv
module ddr2_beat_engine
    import ddr2_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              head_due,
    input  burst_cmd_t        head_cmd,
    output logic              pop,
    output logic              active,
    output logic              last,
    output logic [2:0]        idx,
    output burst_cmd_t        cur,
    output logic [BEATS_PER_CLK-1:0][COL_W-1:0] cols
);

    logic [1:0] pair_q;
    logic [1:0] last_pair;
    logic       active_q;
    burst_cmd_t cur_q;

    assign last_pair = cur_q.bl8 ? 2'd3 : 2'd1;
    assign last      = active_q && (pair_q == last_pair);
    assign pop       = head_due && (!active_q || last);
    assign active    = active_q;
    assign cur       = cur_q;
    assign idx       = {pair_q, 1'b0};

    generate
        for (genvar g = 0; g < BEATS_PER_CLK; g++) begin : g_edge
            assign cols[g] = beat_column(cur_q.col, {pair_q, 1'(g)}, cur_q.bl8, cur_q.ilv);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            pair_q   <= '0;
            cur_q    <= '0;
        end else if (pop) begin
            active_q <= 1'b1;
            pair_q   <= '0;
            cur_q    <= head_cmd;
        end else if (last) begin
            active_q <= 1'b0;
        end else if (active_q) begin
            pair_q   <= pair_q + 1'b1;
        end
    end

    AST_BURST_STEP: assert property (@(posedge clk) disable iff (rst)
        (active_q && !last) |=> (active_q && (pair_q == $past(pair_q) + 2'd1))); // R5

    AST_PAIR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        active_q |-> (pair_q <= last_pair)); // R5

    AST_GAPLESS_CHAIN: assert property (@(posedge clk) disable iff (rst)
        (last && head_due) |=> (active_q && (pair_q == 2'd0))); // R8

endmodule

// File: rtl/ddr2_burst_seq.sv
module ddr2_burst_seq
    import ddr2_seq_pkg::*;
#(
    parameter int QDEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic              cmd_autopre,
    output logic              beat_valid,
    output logic              beat_write,
    output logic [BANK_W-1:0] beat_bank,
    output logic [2:0]        beat_idx,
    output logic [COL_W-1:0]  beat_col_rise,
    output logic [COL_W-1:0]  beat_col_fall,
    output logic              beat_last,
    output logic              pre_req
);

    mode_t             mode;
    burst_cmd_t        new_cmd, head_cmd, cur;
    logic [WAIT_W-1:0] new_wait;
    logic              push, pop, head_due, not_full;
    logic              active, last;
    logic [BEATS_PER_CLK-1:0][COL_W-1:0] cols;

    ddr2_mode_reg i_mode (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr),
        .wr_mode (mode_t'(cfg_wdata)),
        .mode    (mode)
    );

    assign cfg_rdata = mode;
    assign cmd_ready = not_full;
    assign push      = cmd_valid && not_full;
    assign new_wait  = due_wait(mode, cmd_write);

    always_comb begin
        new_cmd         = '0;
        new_cmd.wr      = cmd_write;
        new_cmd.autopre = cmd_autopre;
        new_cmd.bl8     = mode.bl8;
        new_cmd.ilv     = mode.ilv;
        new_cmd.bank    = cmd_bank;
        new_cmd.col     = cmd_col;
    end

    ddr2_cmd_queue #(.DEPTH(QDEPTH)) i_queue (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_cmd  (new_cmd),
        .push_wait (new_wait),
        .pop       (pop),
        .head_cmd  (head_cmd),
        .head_due  (head_due),
        .not_full  (not_full)
    );

    ddr2_beat_engine i_engine (
        .clk      (clk),
        .rst      (rst),
        .head_due (head_due),
        .head_cmd (head_cmd),
        .pop      (pop),
        .active   (active),
        .last     (last),
        .idx      (beat_idx),
        .cur      (cur),
        .cols     (cols)
    );

    assign beat_valid    = active;
    assign beat_write    = cur.wr;
    assign beat_bank     = cur.bank;
    assign beat_col_rise = cols[0];
    assign beat_col_fall = cols[1];
    assign beat_last     = last;
    assign pre_req       = last && cur.autopre;

    AST_PRE_AT_END: assert property (@(posedge clk) disable iff (rst)
        pre_req |-> (beat_valid && beat_last)); // R10

    AST_LAST_ENDS_OR_CHAINS: assert property (@(posedge clk) disable iff (rst)
        (beat_last && !pop) |=> !beat_valid); // R5

endmodule

// File: tb/test_ddr2_burst_seq.sv
`timescale 1ns/1ps
module test_ddr2_burst_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        cmd_valid = 1'b0, cmd_ready, cmd_write = 1'b0, cmd_autopre = 1'b0;
    logic [10:0] cmd_col = '0;
    logic [1:0]  cmd_bank = '0;
    logic        beat_valid, beat_write, beat_last, pre_req;
    logic [1:0]  beat_bank;
    logic [2:0]  beat_idx;
    logic [10:0] beat_col_rise, beat_col_fall;

    ddr2_burst_seq i_ddr2_burst_seq (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_col(cmd_col), .cmd_bank(cmd_bank), .cmd_autopre(cmd_autopre),
        .beat_valid(beat_valid), .beat_write(beat_write), .beat_bank(beat_bank),
        .beat_idx(beat_idx), .beat_col_rise(beat_col_rise), .beat_col_fall(beat_col_fall),
        .beat_last(beat_last), .pre_req(pre_req)
    );

    always #4 clk = ~clk;   // 125 MHz

    typedef struct {
        int    cyc;
        int    c0;
        int    c1;
        int    idx;
        bit    last;
        bit    wr;
        bit    pre;
        int    bank;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;
    // model of the mode register
    int   m_cl = 3, m_al = 0;
    bit   m_bl8 = 1'b0, m_ilv = 1'b0;
    int   last_end = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int exp_col(int c, int i, bit bl8, bit ilv);
        if (ilv) return c ^ i;
        if (!bl8) return (c & ~3) | (((c & 3) + i) % 4);
        return (c & ~7) | ((((c >> 2) & 1) ^ (i / 4)) << 2) | (((c & 3) + i) % 4);
    endfunction

    task automatic chk(string req, int act, int expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // caller is at a negedge; returns at the next negedge
    task automatic cfg_write(logic [7:0] v);
        int cl, al;
        cfg_wr = 1'b1;
        cfg_wdata = v;
        cl = int'(v[2:0]);
        al = int'(v[5:3]);
        if (cl >= 3 && cl <= 5 && al <= 5) begin
            m_cl = cl; m_al = al; m_bl8 = v[6]; m_ilv = v[7];
        end
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // driver: issues one command and pushes the predicted beat pairs
    task automatic send(bit wr, int col, int bank, bit ap);
        int accept, lat, start, np;
        string tag;
        cmd_valid = 1'b1;
        cmd_write = wr;
        cmd_col = 11'(col);
        cmd_bank = 2'(bank);
        cmd_autopre = ap;
        accept = cyc + 1;
        lat = m_al + m_cl - (wr ? 1 : 0);
        start = accept + lat;
        if (last_end > start) start = last_end;
        np = m_bl8 ? 4 : 2;
        tag = {wr ? "R4" : "R3", "/R5/", m_ilv ? "R7" : "R6", "/R8/R9/R10"};
        for (int p = 0; p < np; p++) begin
            exp_t e;
            e.cyc = start + p;
            e.c0 = exp_col(col, 2 * p, m_bl8, m_ilv);
            e.c1 = exp_col(col, 2 * p + 1, m_bl8, m_ilv);
            e.idx = 2 * p;
            e.last = (p == np - 1);
            e.wr = wr;
            e.pre = ap && (p == np - 1);
            e.bank = bank;
            e.tag = tag;
            exp_q.push_back(e);
        end
        last_end = start + np;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // monitor: compares each beat pair against the scoreboard
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (beat_valid) begin
                checks++;
                if (exp_q.size() == 0) begin
                    failures++;
                    $display("FAIL R8 unexpected beat at cyc=%0d col=%0h expected none", cyc, beat_col_rise);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (cyc != e.cyc || int'(beat_col_rise) != e.c0 || int'(beat_col_fall) != e.c1 ||
                        int'(beat_idx) != e.idx || beat_last != e.last || beat_write != e.wr ||
                        pre_req != e.pre || int'(beat_bank) != e.bank) begin
                        failures++;
                        $display("FAIL %s actual cyc=%0d col=%0h/%0h idx=%0d last=%0b wr=%0b pre=%0b bank=%0d expected cyc=%0d col=%0h/%0h idx=%0d last=%0b wr=%0b pre=%0b bank=%0d",
                                 e.tag, cyc, beat_col_rise, beat_col_fall, beat_idx, beat_last, beat_write, pre_req, beat_bank,
                                 e.cyc, e.c0, e.c1, e.idx, e.last, e.wr, e.pre, e.bank);
                    end
                end
            end else begin
                if (exp_q.size() != 0 && exp_q[0].cyc < cyc) begin
                    exp_t e;
                    e = exp_q.pop_front();
                    checks++;
                    failures++;
                    $display("FAIL %s missing beat actual none expected at cyc=%0d idx=%0d", e.tag, e.cyc, e.idx);
                end
                if (pre_req) begin
                    checks++;
                    failures++;
                    $display("FAIL R10 pre_req while idle actual=1 expected=0");
                end
            end
        end
    end

    initial begin
        #(8ns * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // reset state
        chk("R1 reset mode", int'(cfg_rdata), 'h03);
        chk("R5 idle after reset", int'(beat_valid), 0);
        chk("R10 no precharge after reset", int'(pre_req), 0);
        chk("R11 ready after reset", int'(cmd_ready), 1);

        // burst of 4, sequential, CL3 AL0
        send(1'b0, 'h5, 1, 1'b0);
        drain();
        send(1'b1, 'h1E, 0, 1'b0);
        drain();

        // burst of 8 sequential, CL5 AL2 (0x55)
        cfg_write(8'h55);
        chk("R1 readback", int'(cfg_rdata), 'h55);
        send(1'b0, 'h0D, 3, 1'b0);
        drain();
        send(1'b1, 'h16, 1, 1'b1);
        drain();

        // illegal mode writes are dropped (R2)
        cfg_write(8'h02);
        chk("R2 CL=2 ignored", int'(cfg_rdata), 'h55);
        cfg_write(8'h06);
        chk("R2 CL=6 ignored", int'(cfg_rdata), 'h55);
        cfg_write(8'h33);
        chk("R2 AL=6 ignored", int'(cfg_rdata), 'h55);
        send(1'b0, 'h7A1, 2, 1'b0);   // latency still AL2+CL5
        drain();

        // interleaved burst of 8, CL4 AL1 (0xCC), with auto-precharge
        cfg_write(8'hCC);
        chk("R1 readback interleaved", int'(cfg_rdata), 'hCC);
        send(1'b0, 'h13, 2, 1'b1);
        drain();
        send(1'b1, 'h6E, 3, 1'b0);
        drain();

        // interleaved burst of 4, CL3 AL0 (0x83)
        cfg_write(8'h83);
        send(1'b0, 'h2B, 0, 1'b1);
        drain();

        // queued back-to-back commands, sequential burst of 8 (0x43)
        cfg_write(8'h43);
        send(1'b0, 'h1, 0, 1'b0);
        send(1'b0, 'h6, 1, 1'b0);
        send(1'b1, 'h3, 2, 1'b1);
        send(1'b0, 'h4, 3, 1'b0);
        drain();

        // R9: mode changed right after acceptance does not touch the burst in flight
        send(1'b0, 'h9, 1, 1'b0);
        cfg_write(8'h83);
        send(1'b1, 'h5, 2, 1'b0);
        drain();

        // R11: queue fills with long latency AL5 CL5 (0x6D)
        cfg_write(8'h6D);
        send(1'b0, 'h0, 0, 1'b0);
        send(1'b0, 'h8, 1, 1'b0);
        send(1'b0, 'h10, 2, 1'b0);
        send(1'b0, 'h18, 3, 1'b1);
        chk("R11 ready low when queue full", int'(cmd_ready), 0);
        drain();
        chk("R11 ready back after drain", int'(cmd_ready), 1);

        chk("R8 scoreboard empty", exp_q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule